// File: doc/BRIEF.md
# Strobe-Driven FIFO with Half-Full Flag and Rewind

This block is a first-in/first-out buffer of 9-bit words. Producer and consumer each drive an active-low strobe; both strobes, and a separate active-low rewind request, are brought into one system clock domain through a synchronizer and an edge detector. A word is written by a low pulse on the write strobe and read by a low pulse on the read strobe. The memory depth is a parameter.

Three active-low status outputs report the fill state: an empty flag, a full flag and a half-full flag. A rewind pulse sends the read side back to the first slot so that everything written since reset can be read again, while the write side keeps its place. Read data appears on a plain output with a valid qualifier, which stands in for a bus that would otherwise float while no read is in progress.

An accepted strobe is held pending until it rises. Because of this, a read strobe held low on an empty buffer picks up the first word that is written, and a write strobe held low on a full buffer takes the first slot that a read frees.

Top module: `strobe_fifo`

## Requirements
- R1: While `rstN` is low, both pointers return to slot zero and the outputs read `emptyN`=0, `fullN`=1, `halfN`=1 and `dataOutValid`=0.
- R2: Words come out in the order they were written. After a read is accepted, `dataOutValid` is 1 and `dataOut` holds the word. `dataOutValid` returns to 0 once the rising edge of the read strobe has been seen. A strobe edge takes effect 3 clock edges after it is sampled.
- R3: `fullN` goes to 0 as soon as a write is accepted into the last free slot, which is at the falling edge of that write. A write strobe pulse that starts and ends while full is ignored: no word is stored and the write side does not advance.
- R4: `emptyN` goes to 0 when the read that takes the last stored word is accepted. A read strobe pulse that starts and ends while empty is ignored: `dataOutValid` stays 0 and no word is consumed.
- R5: `halfN` is 0 while more than DEPTH/2 slots are held. It falls when the write that crosses that threshold is accepted. It rises only after the rising edge of a read that brings the count to DEPTH/2 or less.
- R6: `fullN` returns to 1 only after the rising edge of a read strobe. `emptyN` returns to 1 only after the rising edge of a write strobe, when the word is committed.
- R7: A low pulse on `rewindN`, given while both strobes are high, sets the read position to slot zero and leaves the write position alone. All three flags then follow the new distance between the two positions.
- R8: Read flow-through. If the read strobe is already low on an empty buffer and one word is written, that word appears with `dataOutValid`=1 after the write commits. `emptyN` is 1 for a single cycle and then returns to 0.
- R9: Write flow-through. If the write strobe is already low on a full buffer and one word is read, `fullN` is 1 for a single cycle and then returns to 0. The pending word is stored at the rising edge of the write strobe and is read out last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStrobeN | input | 1 | Active-low write strobe |
| rdStrobeN | input | 1 | Active-low read strobe |
| rewindN | input | 1 | Active-low rewind request for the read position |
| dataIn | input | WIDTH (9) | Word to store; must be held until 3 clocks after the write strobe rises |
| dataOut | output | WIDTH (9) | Word being read |
| dataOutValid | output | 1 | High while `dataOut` carries an accepted read |
| emptyN | output | 1 | Low when no committed word is left to read |
| fullN | output | 1 | Low when every slot is taken or reserved |
| halfN | output | 1 | Low when more than DEPTH/2 slots are held |

## Verification
The bench targets the exact crossings: the ninth write into a 16-deep buffer, the eighth read back down, the sixteenth write, and a seventeenth write that must vanish. A design with an off-by-one threshold would move `halfN` or `fullN` one word early or late. A design that lets a write through while full would return a stray word at the end of the drain. Rewind is checked after partial reads. It must bring back the first word, raise `halfN`'s occupancy again and keep the write position, so a design that also cleared the write side would lose the later word. The two flow-through cases look for the single-cycle flag pulse and for the pending word. A design that only reacts to strobe edges would hang with `dataOutValid` low, or would drop the held write.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

  // Strobes from the control unit to the storage/datapath unit.
  typedef struct packed {
    logic store;  // commit dataIn into the write slot
    logic load;   // copy the read slot into the output register
    logic drop;   // read finished: clear the output qualifier
  } dpCtl_t;

endpackage

// File: rtl/sfifo_edge.sv
// Brings one active-low strobe into the clock domain and flags a change.
module sfifo_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinN,
  output logic lvl,
  output logic chg
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= pinN;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= {chain[STAGES-2:0], pinN};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prev <= 1'b1;
    else       prev <= chain[LAST];
  end

  assign lvl = chain[LAST];
  assign chg = chain[LAST] ^ prev;

endmodule

// File: rtl/sfifo_ctrl.sv
// Pointer control and flag logic.
module sfifo_ctrl
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrLvl,
  input  logic                     wrChg,
  input  logic                     rdLvl,
  input  logic                     rdChg,
  input  logic                     rwLvl,
  input  logic                     rwChg,
  output dpCtl_t                   ctl,
  output logic [$clog2(DEPTH)-1:0] wrAddr,
  output logic [$clog2(DEPTH)-1:0] rdAddr,
  output logic                     emptyN,
  output logic                     fullN,
  output logic                     halfN
);

  localparam int AW   = $clog2(DEPTH);
  localparam int PW   = AW + 1;
  localparam int HALF = DEPTH / 2;

  // Reserved and committed positions, one bit wider than the address.
  logic [PW-1:0] wrRes, wrCom, rdRes, rdRel;
  logic          wrActive, rdActive;
  logic [PW-1:0] usedSlots;
  logic          isFull, isEmpty, isHalf;
  logic          wrTake, wrDone, rdTake, rdDone, rewindNow;
  logic          wrRise, rdRise, rwFall;

  assign wrRise = wrChg & wrLvl;
  assign rdRise = rdChg & rdLvl;
  assign rwFall = rwChg & ~rwLvl;

  assign usedSlots = wrRes - rdRel;
  assign isFull    = (usedSlots == PW'(DEPTH));
  assign isEmpty   = (wrCom == rdRes);
  assign isHalf    = (usedSlots > PW'(HALF));

  // Rewind only with both strobes high and nothing in flight.
  assign rewindNow = rwFall & wrLvl & rdLvl & ~wrActive & ~rdActive;

  // A low strobe is accepted once per pulse, as soon as the flag allows.
  assign wrTake = ~wrLvl & ~wrActive & ~isFull;
  assign wrDone = wrRise & wrActive;
  assign rdTake = ~rdLvl & ~rdActive & ~isEmpty & ~rewindNow;
  assign rdDone = rdRise & rdActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrRes    <= '0;
      wrCom    <= '0;
      wrActive <= 1'b0;
    end else begin
      if (wrTake) begin
        wrRes    <= wrRes + PW'(1);
        wrActive <= 1'b1;
      end else if (wrDone) begin
        wrCom    <= wrCom + PW'(1);
        wrActive <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdRes    <= '0;
      rdRel    <= '0;
      rdActive <= 1'b0;
    end else if (rewindNow) begin
      rdRes <= '0;
      rdRel <= '0;
    end else begin
      if (rdTake) begin
        rdRes    <= rdRes + PW'(1);
        rdActive <= 1'b1;
      end else if (rdDone) begin
        rdRel    <= rdRel + PW'(1);
        rdActive <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl       = '0;
    ctl.store = wrDone;
    ctl.load  = rdTake;
    ctl.drop  = rdDone;
  end

  assign wrAddr = wrCom[AW-1:0];
  assign rdAddr = rdRes[AW-1:0];
  assign emptyN = ~isEmpty;
  assign fullN  = ~isFull;
  assign halfN  = ~isHalf;

  // R3: a full buffer never advances the write side.
  p_full_blocks_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    isFull |=> $stable(wrRes));

  // R4: an empty buffer never advances the read side.
  p_empty_blocks_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (isEmpty && !rewindNow) |=> $stable(rdRes));

  // R5: half flag falls on an accepted write, rises on a finished read.
  p_half_set_on_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(halfN) |-> $past(wrTake || rewindNow));
  p_half_clear_on_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halfN) |-> $past(rdDone || rewindNow));

  // R6: full releases on a finished read, empty on a committed write.
  p_full_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fullN) |-> $past(rdDone));
  p_empty_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(emptyN) |-> $past(wrDone || rewindNow));

  // R7: rewind zeroes the read side and keeps the write side.
  p_rewind_keeps_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    rewindNow |=> (rdRes == '0 && rdRel == '0 && $stable(wrRes)));

  // R1: the two flags never claim empty and full together.
  p_flags_exclusive_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(!emptyN && !fullN));

endmodule

// File: rtl/sfifo_datapath.sv
// Storage array and output register.
module sfifo_datapath
  import strobe_fifo_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtl_t                   ctl,
  input  logic [$clog2(DEPTH)-1:0] wrAddr,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  input  logic [WIDTH-1:0]         dataIn,
  output logic [WIDTH-1:0]         dataOut,
  output logic                     outValid
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ctl.store) mem[wrAddr] <= dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut  <= '0;
      outValid <= 1'b0;
    end else if (ctl.load) begin
      dataOut  <= mem[rdAddr];
      outValid <= 1'b1;
    end else if (ctl.drop) begin
      outValid <= 1'b0;
    end
  end

  // R2: the output qualifier never rises without a load.
  p_valid_from_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(ctl.load));

  // R2: a load never coincides with a store into the same slot.
  p_no_store_load_clash_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.load && ctl.store && wrAddr == rdAddr));

endmodule

// File: rtl/strobe_fifo.sv
// Thin top: strobe synchronizers, control and datapath.
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int WIDTH       = 9,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrStrobeN,
  input  logic             rdStrobeN,
  input  logic             rewindN,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataOutValid,
  output logic             emptyN,
  output logic             fullN,
  output logic             halfN
);

  localparam int AW    = $clog2(DEPTH);
  localparam int NPINS = 3;

  logic [NPINS-1:0] pinVec, lvlVec, chgVec;
  dpCtl_t           ctl;
  logic [AW-1:0]    wrAddr, rdAddr;

  assign pinVec = {rewindN, rdStrobeN, wrStrobeN};

  generate
    for (genvar g = 0; g < NPINS; g++) begin : g_sync
      sfifo_edge #(.STAGES(SYNC_STAGES)) i_edge (
        .clk  (clk),
        .rstN (rstN),
        .pinN (pinVec[g]),
        .lvl  (lvlVec[g]),
        .chg  (chgVec[g])
      );
    end
  endgenerate

  sfifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrLvl  (lvlVec[0]),
    .wrChg  (chgVec[0]),
    .rdLvl  (lvlVec[1]),
    .rdChg  (chgVec[1]),
    .rwLvl  (lvlVec[2]),
    .rwChg  (chgVec[2]),
    .ctl    (ctl),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .emptyN (emptyN),
    .fullN  (fullN),
    .halfN  (halfN)
  );

  sfifo_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .dataIn   (dataIn),
    .dataOut  (dataOut),
    .outValid (dataOutValid)
  );

endmodule

// File: tb/test_strobe_fifo.sv
module test_strobe_fifo;

  localparam int DEPTH = 16;
  localparam int WIDTH = 9;
  localparam int WATCHDOG = 50000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrStrobeN = 1'b1;
  logic             rdStrobeN = 1'b1;
  logic             rewindN = 1'b1;
  logic [WIDTH-1:0] dataIn = '0;
  logic [WIDTH-1:0] dataOut;
  logic             dataOutValid, emptyN, fullN, halfN;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  strobe_fifo i_strobe_fifo (
    .clk(clk), .rstN(rstN), .wrStrobeN(wrStrobeN), .rdStrobeN(rdStrobeN),
    .rewindN(rewindN), .dataIn(dataIn), .dataOut(dataOut),
    .dataOutValid(dataOutValid), .emptyN(emptyN), .fullN(fullN), .halfN(halfN)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // Strobes are seen two clocks late, an edge one clock after that.
  bit wh1, wh2, wh3, rh1, rh2, rh3, xh1, xh2, xh3;
  int mWres, mWcom, mRres, mRrel;
  bit mWact, mRact, mValid;
  logic [WIDTH-1:0] tape [int];
  logic [WIDTH-1:0] mData;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {wh1, wh2, wh3, rh1, rh2, rh3, xh1, xh2, xh3} = '1;
      mWres = 0; mWcom = 0; mRres = 0; mRrel = 0;
      mWact = 0; mRact = 0; mValid = 0; mData = '0;
      tape.delete();
    end else begin
      bit full, empty, rew, wTake, wDone, rTake, rDone;
      full  = (mWres - mRrel) == DEPTH;
      empty = (mWcom == mRres);
      rew   = (!xh2 && xh3) && wh2 && rh2 && !mWact && !mRact;
      wTake = !wh2 && !mWact && !full;
      wDone = wh2 && !wh3 && mWact;
      rTake = !rh2 && !mRact && !empty && !rew;
      rDone = rh2 && !rh3 && mRact;
      if (wDone) begin tape[mWcom] = dataIn; mWcom++; mWact = 0; end
      if (wTake) begin mWres++; mWact = 1; end
      if (rew) begin mRres = 0; mRrel = 0; end
      if (rTake) begin mData = tape[mRres]; mValid = 1; mRres++; mRact = 1; end
      if (rDone) begin mValid = 0; mRrel++; mRact = 0; end
      wh3 = wh2; wh2 = wh1; wh1 = wrStrobeN;
      rh3 = rh2; rh2 = rh1; rh1 = rdStrobeN;
      xh3 = xh2; xh2 = xh1; xh1 = rewindN;
    end
  end

  // Per-cycle comparison, away from the active edge.
  bit sawEmptyHigh, sawFullHigh;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R4", "emptyN vs model", emptyN, (mWcom != mRres));
      check("R3", "fullN vs model", fullN, ((mWres - mRrel) != DEPTH));
      check("R5", "halfN vs model", halfN, ((mWres - mRrel) <= DEPTH / 2));
      check("R2", "valid vs model", dataOutValid, mValid);
      if (mValid) check("R2", "data vs model", dataOut, mData);
      if (emptyN) sawEmptyHigh = 1;
      if (fullN)  sawFullHigh = 1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG && !finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus tasks ----------------
  logic [WIDTH-1:0] got;
  bit gotValid, midFullN, midHalfN;

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrStrobeN = 1'b1; rdStrobeN = 1'b1; rewindN = 1'b1;
    waitN(3);
    rstN = 1'b1;
    waitN(3);
  endtask

  task automatic doWrite(input logic [WIDTH-1:0] d);
    dataIn = d; wrStrobeN = 1'b0;
    waitN(4);
    wrStrobeN = 1'b1;
    waitN(4);
  endtask

  task automatic doRead();
    rdStrobeN = 1'b0;
    waitN(4);
    got = dataOut; gotValid = dataOutValid; midFullN = fullN; midHalfN = halfN;
    rdStrobeN = 1'b1;
    waitN(4);
  endtask

  task automatic doRewind();
    rewindN = 1'b0;
    waitN(4);
    rewindN = 1'b1;
    waitN(4);
  endtask

  initial begin
    waitN(4);
    rstN = 1'b1;
    waitN(3);

    // R1: reset state
    check("R1", "emptyN after reset", emptyN, 0);
    check("R1", "fullN after reset", fullN, 1);
    check("R1", "halfN after reset", halfN, 1);
    check("R1", "valid after reset", dataOutValid, 0);

    // R2/R6: simple order
    doWrite(9'h101); doWrite(9'h0A2); doWrite(9'h1C3);
    check("R6", "emptyN after commits", emptyN, 1);
    doRead(); check("R2", "first word", got, 9'h101); check("R2", "valid mid read", gotValid, 1);
    check("R2", "valid after strobe rise", dataOutValid, 0);
    doRead(); check("R2", "second word", got, 9'h0A2);
    doRead(); check("R2", "third word", got, 9'h1C3);
    check("R4", "emptyN after drain", emptyN, 0);

    // R4: read on empty ignored
    doRead(); check("R4", "read while empty gives no valid", gotValid, 0);
    doWrite(9'h055);
    doRead(); check("R4", "next word after ignored read", got, 9'h055);

    // R3/R5: fill, overflow attempt, drain
    doReset();
    for (int i = 0; i < DEPTH; i++) begin
      doWrite(WIDTH'(9'h040 + i));
      if (i == DEPTH / 2 - 1) check("R5", "halfN at half occupancy", halfN, 1);
      if (i == DEPTH / 2)     check("R5", "halfN just above half", halfN, 0);
      if (i == DEPTH - 2)     check("R3", "fullN one short", fullN, 1);
    end
    check("R3", "fullN at depth", fullN, 0);
    doWrite(9'h1FF);
    check("R3", "fullN after ignored write", fullN, 0);
    for (int i = 0; i < DEPTH; i++) begin
      doRead();
      check("R3", "drain order", got, 9'h040 + i);
      if (i == 0) begin
        check("R6", "fullN held while read strobe low", midFullN, 0);
        check("R6", "fullN after read rise", fullN, 1);
      end
      if (i == DEPTH / 2 - 1) begin
        check("R5", "halfN held while read strobe low", midHalfN, 0);
        check("R5", "halfN after read rise", halfN, 1);
      end
    end
    check("R3", "empty after drain, stray word absent", emptyN, 0);

    // R7: rewind
    doReset();
    for (int i = 0; i < 10; i++) doWrite(WIDTH'(9'h010 + i));
    for (int i = 0; i < 8; i++) doRead();
    check("R7", "halfN before rewind", halfN, 1);
    doRewind();
    check("R7", "halfN after rewind", halfN, 0);
    check("R7", "emptyN after rewind", emptyN, 1);
    for (int i = 0; i < 10; i++) begin
      doRead();
      check("R7", "replayed word", got, 9'h010 + i);
    end
    check("R7", "empty after replay", emptyN, 0);
    doWrite(9'h0F5);
    doRead(); check("R7", "write side kept its place", got, 9'h0F5);

    // R8: read flow-through
    doReset();
    rdStrobeN = 1'b0;
    waitN(6);
    check("R8", "no valid while empty", dataOutValid, 0);
    sawEmptyHigh = 0;
    dataIn = 9'h0AB; wrStrobeN = 1'b0;
    waitN(4);
    wrStrobeN = 1'b1;
    waitN(6);
    check("R8", "valid after flow-through", dataOutValid, 1);
    check("R8", "flow-through word", dataOut, 9'h0AB);
    check("R8", "empty pulse seen", sawEmptyHigh, 1);
    check("R8", "emptyN reasserted", emptyN, 0);
    rdStrobeN = 1'b1;
    waitN(4);
    check("R8", "valid drops after rise", dataOutValid, 0);

    // R9: write flow-through
    doReset();
    for (int i = 0; i < DEPTH; i++) doWrite(WIDTH'(9'h060 + i));
    dataIn = 9'h1EE; wrStrobeN = 1'b0;
    waitN(6);
    check("R9", "fullN while write waits", fullN, 0);
    sawFullHigh = 0;
    doRead();
    check("R9", "read from full", got, 9'h060);
    check("R9", "full pulse seen", sawFullHigh, 1);
    check("R9", "fullN reasserted", fullN, 0);
    wrStrobeN = 1'b1;
    waitN(4);
    for (int i = 1; i < DEPTH; i++) begin
      doRead();
      check("R9", "order before pending word", got, 9'h060 + i);
    end
    doRead();
    check("R9", "pending word stored last", got, 9'h1EE);
    check("R9", "empty at end", emptyN, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule